// File: doc/BRIEF.md
# Ring Oscillator Phase Snapshot Decoder

The block turns one snapshot of a free-running ring oscillator into a fixed-point phase value every sample clock. The ring has an odd number of inverting stages (127 by default), so one full oscillation passes through twice that many distinct sampled states. A snapshot holds every stage output together with two small wrapping cycle counts. One count steps on each rising edge of the first stage and the other on each falling edge. All of these are taken asynchronously to the ring on the rising edge of the sample clock.

The fractional part of the phase comes from where the single break sits in the otherwise alternating stage pattern, together with the level of the first stage. The integer part comes from whichever counter was far from its own edge at the sample instant. Near the rising-edge counter's edge, the falling-edge count is used with a learned correction. That correction is updated in the background in two fixed fraction windows, so the two counters may start at any values relative to each other. A snapshot that holds more than one break is reported as invalid, and the last good result is kept.

Top module: `ring_phase_decoder`

## Requirements
- R1: For a snapshot with exactly one break, the fraction output is defined as follows. A break at position i means stage i equals stage i-1; position 0 means stage 0 equals the last stage. Let k be the last stage before the break (k = 126 for a break at position 0, otherwise i-1). The fraction output is then k when stage 0 is high and 127+k when stage 0 is low, which covers 0..253.
- R2: The stage vector and both counts are captured on a rising clock edge. Outputs and `valid_o` update on the next rising edge, so a result appears two edges after its inputs are presented. Between those two edges the outputs still show the previous result.
- R3: When the decoded fraction lies in 63..189, the cycle output equals the captured rising-edge count.
- R4: The correction is updated only on a valid snapshot. For a fraction in 53..73 it becomes (rise − fall − 1) mod 16. For a fraction in 180..200 it becomes (rise − fall) mod 16. Otherwise it keeps its value.
- R5: For a fraction in 190..253 the cycle output is (fall + correction) mod 16. For a fraction in 0..62 it is (fall + correction + 1) mod 16. In both cases the correction used is the one that results from the same snapshot under R4.
- R6: A snapshot whose break count is not exactly one gives `err_o` = 1 and `valid_o` = 0 one edge after capture. The fraction and cycle outputs stay unchanged, and the correction is not updated.
- R7: Reset clears the fraction and cycle outputs, `valid_o`, `err_o` and the correction to 0.
- R8: Once the correction has been learned in either window, the cycle output equals the true count of completed rising edges (mod 16) plus the rising counter's start value. This holds for any start values of the two counters, and whatever a counter shows within a few fraction steps of its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stage_i | input | 127 | Ring stage outputs, bit 0 is the first stage |
| rise_cnt_i | input | 4 | Count stepped by rising edges of the first stage |
| fall_cnt_i | input | 4 | Count stepped by falling edges of the first stage |
| frac_o | output | 10 | Fractional phase in steps of 1/254 cycle |
| cyc_o | output | 4 | Integer cycle count, wrapping |
| valid_o | output | 1 | Result of a well-formed snapshot is on the outputs |
| err_o | output | 1 | Last snapshot had a malformed stage pattern |

## Verification
The learning window at 190..200 overlaps the region where the falling-edge count is selected. In those cycles the correction update and the cycle-output computation act on the same snapshot. The bench provokes this both by directed phases at 190 and 200 right after reset or counter-offset changes, and by random phase steps that often land there. In each case it expects the freshly learned value to take effect at once. Malformed snapshots are also placed where the decoded phase would fall inside a learning window, and the next good snapshot in the falling-count region shows whether the correction stayed untouched.

// File: rtl/ring_phase_decoder.sv
module ring_phase_decoder #(
  parameter int STAGES     = 127,
  parameter int CNT_W      = 4,
  parameter int FRAC_W     = 10,
  parameter int LEARN_HALF = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] stage_i,
  input  logic [CNT_W-1:0]  rise_cnt_i,
  input  logic [CNT_W-1:0]  fall_cnt_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [CNT_W-1:0]  cyc_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int PHASES = 2 * STAGES;
  localparam int QTR    = STAGES / 2;
  localparam int IDX_W  = $clog2(STAGES);
  localparam int BC_W   = $clog2(STAGES + 1);
  localparam logic [FRAC_W-1:0] RISE_LO = FRAC_W'(QTR);
  localparam logic [FRAC_W-1:0] RISE_HI = FRAC_W'(QTR + STAGES - 1);
  localparam logic [FRAC_W-1:0] LA_LO   = FRAC_W'(QTR - LEARN_HALF);
  localparam logic [FRAC_W-1:0] LA_HI   = FRAC_W'(QTR + LEARN_HALF);
  localparam logic [FRAC_W-1:0] LB_LO   = FRAC_W'(QTR + STAGES - LEARN_HALF);
  localparam logic [FRAC_W-1:0] LB_HI   = FRAC_W'(QTR + STAGES + LEARN_HALF);

  logic [STAGES-1:0] stg_q;
  logic [CNT_W-1:0]  rise_q, fall_q, corr_q;
  logic              cap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stg_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      cap_q  <= 1'b0;
    end else begin
      stg_q  <= stage_i;
      rise_q <= rise_cnt_i;
      fall_q <= fall_cnt_i;
      cap_q  <= 1'b1;
    end

  logic [STAGES-1:0] brk;
  assign brk[0] = stg_q[0] == stg_q[STAGES-1];
  for (genvar i = 1; i < STAGES; i++) begin : g_brk
    assign brk[i] = stg_q[i] == stg_q[i-1];
  end

  logic [BC_W-1:0]  nbrk;
  logic [IDX_W-1:0] idx;
  always_comb begin
    nbrk = '0;
    idx  = '0;
    for (int i = STAGES - 1; i >= 0; i--)
      if (brk[i]) begin
        nbrk = nbrk + BC_W'(1);
        idx  = IDX_W'(i);
      end
  end

  logic [IDX_W-1:0]  last;
  logic [FRAC_W-1:0] frac;
  logic              ok, bad, in_rise, learn_a, learn_b, learn;
  logic [CNT_W-1:0]  corr_nxt, cyc;

  assign ok      = cap_q && (nbrk == BC_W'(1));
  assign bad     = cap_q && (nbrk != BC_W'(1));
  assign last    = (idx == '0) ? IDX_W'(STAGES - 1) : idx - IDX_W'(1);
  assign frac    = stg_q[0] ? FRAC_W'(last) : FRAC_W'(last) + FRAC_W'(STAGES);
  assign in_rise = frac >= RISE_LO && frac <= RISE_HI;
  assign learn_a = frac >= LA_LO && frac <= LA_HI;
  assign learn_b = frac >= LB_LO && frac <= LB_HI;
  assign learn   = ok && (learn_a || learn_b);

  assign corr_nxt = learn_a ? rise_q - fall_q - CNT_W'(1) :
                    learn_b ? rise_q - fall_q : corr_q;
  assign cyc = in_rise         ? rise_q :
               (frac < RISE_LO) ? fall_q + corr_nxt + CNT_W'(1) :
                                  fall_q + corr_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      corr_q  <= '0;
      frac_o  <= '0;
      cyc_o   <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= ok;
      err_o   <= bad;
      if (ok) begin
        corr_q <= corr_nxt;
        frac_o <= frac;
        cyc_o  <= cyc;
      end
    end

  p_frac_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> frac_o < FRAC_W'(PHASES));
  p_valid_after_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(cap_q));
  p_rise_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && frac_o >= RISE_LO && frac_o <= RISE_HI) |-> cyc_o == $past(rise_q));
  p_corr_learn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(corr_q) |-> $past(learn));
  p_hold_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(frac_o) && $stable(cyc_o) && !valid_o));
  p_corr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bad) |-> $stable(corr_q));
endmodule

// File: tb/ring_phase_decoder_bench.sv
module ring_phase_decoder_bench;
  localparam int PERIOD = 10;
  localparam int N = 127;
  localparam int PH = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] stage_i = '0;
  logic [3:0]   rise_cnt_i = '0, fall_cnt_i = '0;
  logic [9:0]   frac_o;
  logic [3:0]   cyc_o;
  logic         valid_o, err_o;

  ring_phase_decoder u_ring_phase_decoder (
    .clk(clk), .rst_n(rst_n), .stage_i(stage_i),
    .rise_cnt_i(rise_cnt_i), .fall_cnt_i(fall_cnt_i),
    .frac_o(frac_o), .cyc_o(cyc_o), .valid_o(valid_o), .err_o(err_o));

  always #(PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int r0, f0, corr_m, last_frac, last_cyc;
  bit learned;

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] ring_vec(input int f);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      if (f < N) v[i] = (i <= f) ? ~i[0] : i[0];
      else       v[i] = (i <= f - N) ? i[0] : ~i[0];
    end
    return v;
  endfunction

  function automatic int brk_pos(input int f);
    return (f < N) ? (f + 1) % N : (f - N + 1) % N;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    corr_m = 0; learned = 0; last_frac = 0; last_cyc = 0;
    chk(valid_o == 0 && err_o == 0, "R7 flags after reset", {valid_o, err_o}, 0);
    chk(frac_o == 0 && cyc_o == 0, "R7 outputs after reset", {frac_o, cyc_o}, 0);
  endtask

  task automatic snap(input int ph, input bit corrupt);
    int f, c, rc, fc, ex, j;
    logic [N-1:0] v;
    f = ph % PH; c = ph / PH;
    v = ring_vec(f);
    if (corrupt) begin
      j = (brk_pos(f) + 60) % N;
      v[j] = ~v[j];
    end
    rc = r0 + c;
    if (f <= 3) rc = rc - int'($urandom % 2);
    if (f >= PH - 4) rc = rc + int'($urandom % 2);
    fc = f0 + c + ((f >= N) ? 1 : 0);
    if (f >= N - 3 && f < N) fc = fc + int'($urandom % 2);
    if (f >= N && f <= N + 3) fc = fc - int'($urandom % 2);
    rc = rc & 15; fc = fc & 15;
    stage_i = v; rise_cnt_i = rc[3:0]; fall_cnt_i = fc[3:0];
    @(posedge clk); @(negedge clk);
    chk(frac_o == last_frac && cyc_o == last_cyc, "R2 hold before result edge", frac_o, last_frac);
    @(posedge clk); @(negedge clk);
    if (corrupt) begin
      chk(err_o == 1 && valid_o == 0, "R6 flags on malformed snapshot", {err_o, valid_o}, 2);
      chk(frac_o == last_frac && cyc_o == last_cyc, "R6 outputs held", frac_o, last_frac);
    end else begin
      if (f >= 53 && f <= 73)   begin corr_m = (rc - fc - 1) & 15; learned = 1; end
      if (f >= 180 && f <= 200) begin corr_m = (rc - fc) & 15;     learned = 1; end
      if (f >= 63 && f <= 189) ex = rc;
      else if (f < 63)         ex = (fc + corr_m + 1) & 15;
      else                     ex = (fc + corr_m) & 15;
      chk(valid_o == 1 && err_o == 0, "R2 valid after two edges", {valid_o, err_o}, 2);
      chk(int'(frac_o) == f, "R1 fraction decode", frac_o, f);
      if (f >= 63 && f <= 189) chk(int'(cyc_o) == ex, "R3 rising count pick", cyc_o, ex);
      else                     chk(int'(cyc_o) == ex, "R5 falling count plus correction (R4)", cyc_o, ex);
      if (learned) chk(int'(cyc_o) == ((r0 + c) & 15), "R8 true cycle count", cyc_o, (r0 + c) & 15);
      last_frac = int'(frac_o); last_cyc = int'(cyc_o);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ph, seed;
    seed = $urandom(32'd20571);
    r0 = 9; f0 = 2;
    do_reset();
    snap(10, 0);              // R7: correction starts at 0
    snap(PH + 195, 0);        // R4/R5 overlap of learning and fall pick
    snap(2 * PH + 0, 0);
    snap(2 * PH + 62, 0);
    snap(2 * PH + 63, 0);
    snap(2 * PH + 126, 0);
    snap(2 * PH + 127, 0);
    snap(2 * PH + 189, 0);
    snap(2 * PH + 190, 0);
    snap(2 * PH + 253, 0);
    snap(3 * PH + 60, 1);     // R6 malformed inside learning window
    snap(3 * PH + 5, 0);
    r0 = 4; f0 = 13;
    do_reset();
    snap(PH + 190, 0);        // first learn lands in overlap
    snap(PH + 200, 0);
    snap(PH + 53, 0);
    snap(PH + 73, 0);
    snap(PH + 180, 0);
    ph = 2 * PH;
    for (int k = 0; k < 1500; k++) begin
      ph = ph + 1 + int'($urandom % 400);
      snap(ph, ($urandom % 16) == 0);
    end
    r0 = int'($urandom % 16); f0 = int'($urandom % 16);
    do_reset();
    ph = 7;
    for (int k = 0; k < 500; k++) begin
      ph = ph + 1 + int'($urandom % 300);
      snap(ph, ($urandom % 20) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule